// File: doc/BRIEF.md
# Prioritised Nested Interrupt Controller

This block sits between a set of maskable interrupt request lines and a processor core. It decides which request the core should take next. For every line it keeps an enable bit, a pending bit, an active bit and a two-bit urgency. A lower urgency value means a more urgent line. The controller drives a request to the core together with the vector number of the winning line, and it takes two pulses back from the core: one when a handler actually begins (entry acknowledge) and one when a handler finishes (exit).

Running handlers nest in strict order of urgency. An internal stack records the urgency level and the line of each running handler, so every exit restores the level of the handler it interrupted. The vector offered to the core is recomputed every cycle until the core acknowledges entry. A more urgent request that arrives late in the entry phase therefore replaces the earlier one. At exit, the controller flags whether another pending line can be chained straight in, or whether the core returns to thread state.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A line's pending bit is set by a 0-to-1 transition on its request input or by a one-cycle pulse on its software set bit, and is cleared by its software clear bit. When set and clear arrive in the same cycle, set wins. The pending bits are visible on `pend_out`, with bit i belonging to line i.
- R2: `irq_req` is high exactly when some line is enabled, pending and not active, and its urgency is numerically below `cur_lvl`. A disabled line never raises a request, but it keeps its pending bit.
- R3: Among the candidate lines, the one with the smallest urgency value wins. On a tie, the lowest line number wins. The winner is presented on `irq_vec`.
- R4: A request whose urgency equals the level of the running handler does not preempt it. Only a strictly smaller value does.
- R5: Until the core acknowledges entry, `irq_vec` follows the current winner, so a more urgent late arrival replaces the earlier vector. An entry acknowledge while `irq_req` is high takes the vector shown in that cycle. On the next cycle, that line's active bit is set, its pending bit is cleared, and `cur_lvl` equals its urgency.
- R6: An exit pops the most recent handler, clears its active bit and restores `cur_lvl` to the level of the handler it interrupted. With no handler left, `cur_lvl` returns to 4 (background, encoded one step beyond the least urgent level).
- R7: During an exit cycle, `tail_chain` is high when a candidate line is more urgent than the level that remains after the pop. `thread_ret` is high when the last handler exits and nothing chains. The two are never high together.
- R8: After reset, nothing is pending or active, `irq_req` is low and `cur_lvl` is 4.
- R9: An entry acknowledge while `irq_req` is low, and an exit while no handler is running, leave the active bits and `cur_lvl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | Request lines, edge sensitive |
| en_mask | input | NUM_IRQ | Per-line enable |
| prio_cfg | input | NUM_IRQ*PRIO_W | Urgency of line i in bits [i*PRIO_W +: PRIO_W] |
| pend_set | input | NUM_IRQ | Software set of pending bits |
| pend_clr | input | NUM_IRQ | Software clear of pending bits |
| core_ack | input | 1 | Core begins the handler for `irq_vec` |
| core_exit | input | 1 | Core finishes the current handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | $clog2(NUM_IRQ) | Winning line number |
| tail_chain | output | 1 | Exit chains straight into the next handler |
| thread_ret | output | 1 | Exit returns to thread state |
| cur_lvl | output | PRIO_W+1 | Level of the running handler, 4 when idle |
| pend_out | output | NUM_IRQ | Pending bits |
| act_out | output | NUM_IRQ | Active bits |

## Verification
The bench uses the default values NUM_IRQ=32 and PRIO_W=2. This gives the full four-level urgency range, and the stack can nest down to level 0 and unwind one level at a time. With 32 lines the bench can place ties at scattered line numbers, so lowest-number wins is checked across non-adjacent lines. The bench also drives a late arrival at level 0 that replaces a pending level-1 vector, and a chain of four handlers taken in turn at exit, ending in a return to thread state.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic [1:0] {
    EXIT_NONE   = 2'd0,
    EXIT_UNWIND = 2'd1,
    EXIT_CHAIN  = 2'd2,
    EXIT_THREAD = 2'd3
  } exit_kind_e;

  function automatic exit_kind_e classify_exit(input logic exit_ok, input logic chain_ok,
                                               input logic last_one);
    if (!exit_ok)      return EXIT_NONE;
    else if (chain_ok) return EXIT_CHAIN;
    else if (last_one) return EXIT_THREAD;
    else               return EXIT_UNWIND;
  endfunction
endpackage

// File: rtl/irq_nest_pend.sv
module irq_nest_pend #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] sw_set,
  input  logic [NUM_IRQ-1:0] sw_clr,
  input  logic [NUM_IRQ-1:0] take_mask,
  output logic [NUM_IRQ-1:0] pend,
  output logic [NUM_IRQ-1:0] rise
);
  logic [NUM_IRQ-1:0] prev_q;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= irq_in;
      pend   <= (pend & ~sw_clr & ~take_mask) | rise | sw_set;
    end
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  localparam int IW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]        ok,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_cfg,
  output logic                      win_v,
  output logic [IW-1:0]             win_id,
  output logic [PRIO_W-1:0]         win_p
);
  // Scan from the top line down; "<=" lets a lower number take a tie.
  always_comb begin
    win_v  = 1'b0;
    win_id = '0;
    win_p  = '1;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (ok[i] && (!win_v || prio_cfg[i*PRIO_W +: PRIO_W] <= win_p)) begin
        win_v  = 1'b1;
        win_id = IW'(i);
        win_p  = prio_cfg[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  localparam int IW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int LEVELS = 1 << PRIO_W,
  localparam int LW     = PRIO_W + 1,
  localparam int DW     = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [IW-1:0]      push_id,
  input  logic [PRIO_W-1:0]  push_p,
  input  logic               pop,
  output logic [LW-1:0]      cur_lvl,
  output logic [LW-1:0]      post_lvl,
  output logic [DW-1:0]      depth,
  output logic [NUM_IRQ-1:0] active
);
  localparam logic [LW-1:0] BG = LW'(LEVELS);

  logic [LW-1:0] lvl_q [LEVELS];
  logic [IW-1:0] id_q  [LEVELS];
  logic [IW-1:0] top_id;

  always_comb begin
    cur_lvl  = BG;
    post_lvl = BG;
    top_id   = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (DW'(k + 1) == depth) begin
        cur_lvl = lvl_q[k];
        top_id  = id_q[k];
      end
      if (DW'(k + 2) == depth) post_lvl = lvl_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth  <= '0;
      active <= '0;
      for (int k = 0; k < LEVELS; k++) begin
        lvl_q[k] <= BG;
        id_q[k]  <= '0;
      end
    end else if (pop) begin
      depth  <= depth - DW'(1);
      active <= active & ~(NUM_IRQ'(1) << top_id);
    end else if (push && depth != DW'(LEVELS)) begin
      depth  <= depth + DW'(1);
      active <= active | (NUM_IRQ'(1) << push_id);
      for (int k = 0; k < LEVELS; k++) begin
        if (DW'(k) == depth) begin
          lvl_q[k] <= {1'b0, push_p};
          id_q[k]  <= push_id;
        end
      end
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  localparam int IW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int LW     = PRIO_W + 1,
  localparam int DW     = $clog2((1 << PRIO_W) + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_in,
  input  logic [NUM_IRQ-1:0]        en_mask,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_cfg,
  input  logic [NUM_IRQ-1:0]        pend_set,
  input  logic [NUM_IRQ-1:0]        pend_clr,
  input  logic                      core_ack,
  input  logic                      core_exit,
  output logic                      irq_req,
  output logic [IW-1:0]             irq_vec,
  output logic                      tail_chain,
  output logic                      thread_ret,
  output logic [LW-1:0]             cur_lvl,
  output logic [NUM_IRQ-1:0]        pend_out,
  output logic [NUM_IRQ-1:0]        act_out
);
  import irq_nest_pkg::*;

  logic [NUM_IRQ-1:0] cand_ok, take_mask, rise;
  logic               win_v, take_ok, exit_ok;
  logic [PRIO_W-1:0]  win_p;
  logic [LW-1:0]      post_lvl;
  logic [DW-1:0]      depth;
  exit_kind_e         exit_kind;

  irq_nest_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sw_set(pend_set), .sw_clr(pend_clr),
    .take_mask(take_mask), .pend(pend_out), .rise(rise)
  );

  assign cand_ok = en_mask & pend_out & ~act_out;

  irq_nest_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .ok(cand_ok), .prio_cfg(prio_cfg), .win_v(win_v), .win_id(irq_vec), .win_p(win_p)
  );

  assign irq_req   = win_v && ({1'b0, win_p} < cur_lvl);
  assign exit_ok   = core_exit && (depth != '0);
  assign take_ok   = core_ack && irq_req && !exit_ok;
  assign take_mask = take_ok ? (NUM_IRQ'(1) << irq_vec) : '0;

  irq_nest_stack #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(take_ok), .push_id(irq_vec), .push_p(win_p),
    .pop(exit_ok), .cur_lvl(cur_lvl), .post_lvl(post_lvl), .depth(depth), .active(act_out)
  );

  assign exit_kind  = classify_exit(exit_ok, win_v && ({1'b0, win_p} < post_lvl),
                                    depth == DW'(1));
  assign tail_chain = (exit_kind == EXIT_CHAIN);
  assign thread_ret = (exit_kind == EXIT_THREAD);
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  localparam int IW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int LW     = PRIO_W + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_IRQ-1:0]        en_mask,
  input logic [NUM_IRQ*PRIO_W-1:0] prio_cfg,
  input logic                      core_ack,
  input logic                      core_exit,
  input logic                      irq_req,
  input logic [IW-1:0]             irq_vec,
  input logic                      tail_chain,
  input logic                      thread_ret,
  input logic [LW-1:0]             cur_lvl,
  input logic [NUM_IRQ-1:0]        pend_out,
  input logic [NUM_IRQ-1:0]        act_out,
  input logic                      take_ok,
  input logic                      exit_ok
);
  logic [PRIO_W-1:0] vec_prio;
  assign vec_prio = prio_cfg[irq_vec*PRIO_W +: PRIO_W];

  assert_req_candidate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_mask[irq_vec] && pend_out[irq_vec] && !act_out[irq_vec]));

  assert_strict_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ({1'b0, vec_prio} < cur_lvl));

  assert_entry_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (act_out[$past(irq_vec)] && cur_lvl == {1'b0, $past(vec_prio)}));

  assert_exit_unwinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ok |=> (cur_lvl > $past(cur_lvl)));

  assert_exit_kinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tail_chain, thread_ret}));

  assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && !irq_req && !core_exit) |=> $stable(act_out));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_mask(en_mask), .prio_cfg(prio_cfg), .core_ack(core_ack),
  .core_exit(core_exit), .irq_req(irq_req), .irq_vec(irq_vec), .tail_chain(tail_chain),
  .thread_ret(thread_ret), .cur_lvl(cur_lvl), .pend_out(pend_out), .act_out(act_out),
  .take_ok(take_ok), .exit_ok(exit_ok)
);

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0, en_mask = '0, pend_set = '0, pend_clr = '0;
  logic [N*PW-1:0] prio_cfg = '0;
  logic          core_ack = 1'b0, core_exit = 1'b0;
  logic          irq_req, tail_chain, thread_ret;
  logic [4:0]    irq_vec;
  logic [2:0]    cur_lvl;
  logic [N-1:0]  pend_out, act_out;

  int total = 0, bad = 0;
  int exp_q[$];

  irq_nest_ctrl #(.NUM_IRQ(N), .PRIO_W(PW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor: scoreboard pops the expected vector at each accepted entry (R5)
  always @(posedge clk) begin
    if (rst_n && core_ack && irq_req) begin
      if (exp_q.size() == 0) chk("R5 unexpected entry", int'(irq_vec), -1);
      else chk("R5 entry vector", int'(irq_vec), exp_q.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic raise(input int line, input int p);
    prio_cfg[line*PW +: PW] = PW'(p);
    irq_in[line] = 1'b1;
    cyc();
  endtask

  task automatic do_ack(input int exp_vec);
    exp_q.push_back(exp_vec);
    core_ack = 1'b1; cyc(); core_ack = 1'b0; #1;
  endtask

  task automatic do_exit(input int exp_chain, input int exp_thread);
    core_exit = 1'b1; #1;
    chk("R7 tail_chain", int'(tail_chain), exp_chain);
    chk("R7 thread_ret", int'(thread_ret), exp_thread);
    cyc(); core_exit = 1'b0; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1; cyc();
    chk("R8 req", int'(irq_req), 0);
    chk("R8 pend", int'(pend_out), 0);
    chk("R8 level", int'(cur_lvl), 4);
    en_mask = '1;

    raise(5, 2);
    chk("R1 edge pend", int'(pend_out[5]), 1);
    chk("R2 req", int'(irq_req), 1);
    chk("R2 vec", int'(irq_vec), 5);
    en_mask[5] = 1'b0; #1;
    chk("R2 disabled req", int'(irq_req), 0);
    chk("R2 disabled keeps pend", int'(pend_out[5]), 1);
    en_mask[5] = 1'b1; #1;

    raise(3, 2);
    chk("R3 tie lowest", int'(irq_vec), 3);
    raise(9, 1);
    chk("R3 urgent wins", int'(irq_vec), 9);
    raise(12, 0);
    chk("R5 late arrival", int'(irq_vec), 12);

    do_ack(12);
    chk("R5 active", int'(act_out[12]), 1);
    chk("R5 pend cleared", int'(pend_out[12]), 0);
    chk("R5 level", int'(cur_lvl), 0);
    chk("R2 none beats 0", int'(irq_req), 0);

    do_exit(1, 0);
    chk("R6 level", int'(cur_lvl), 4);
    chk("R6 inactive", int'(act_out[12]), 0);
    chk("R3 next", int'(irq_vec), 9);

    do_ack(9);
    chk("R4 level", int'(cur_lvl), 1);
    chk("R4 less urgent blocked", int'(irq_req), 0);
    raise(20, 1);
    chk("R4 equal blocked", int'(irq_req), 0);
    raise(2, 0);
    chk("R4 preempt req", int'(irq_req), 1);
    chk("R4 preempt vec", int'(irq_vec), 2);
    do_ack(2);
    chk("R6 nested level", int'(cur_lvl), 0);
    do_exit(0, 0);
    chk("R6 restored", int'(cur_lvl), 1);
    chk("R6 outer active", int'(act_out[9]), 1);

    do_exit(1, 0);
    chk("R6 to background", int'(cur_lvl), 4);
    chk("R7 chained vec", int'(irq_vec), 20);
    do_ack(20);
    do_exit(1, 0);
    do_ack(3);
    do_exit(1, 0);
    do_ack(5);
    do_exit(0, 1);
    chk("R8 idle again", int'(cur_lvl), 4);
    chk("R2 no req", int'(irq_req), 0);
    irq_in = '0;

    pend_set[7] = 1'b1; cyc(); pend_set = '0; #1;
    chk("R1 sw set", int'(pend_out[7]), 1);
    chk("R1 sw set vec", int'(irq_vec), 7);
    pend_clr[7] = 1'b1; cyc(); pend_clr = '0; #1;
    chk("R1 sw clr", int'(pend_out[7]), 0);
    chk("R1 sw clr req", int'(irq_req), 0);
    pend_set[7] = 1'b1; pend_clr[7] = 1'b1; cyc(); pend_set = '0; pend_clr = '0; #1;
    chk("R1 set wins", int'(pend_out[7]), 1);
    pend_clr[7] = 1'b1; cyc(); pend_clr = '0; #1;

    core_ack = 1'b1; cyc(); core_ack = 1'b0; #1;
    chk("R9 stray ack active", int'(act_out), 0);
    chk("R9 stray ack level", int'(cur_lvl), 4);
    do_exit(0, 0);
    chk("R9 stray exit level", int'(cur_lvl), 4);
    chk("R5 scoreboard drained", exp_q.size(), 0);

    summary();
  end
endmodule